// File: doc/BRIEF.md
# Parallel Port Extended-Mode Cycle Gate

This block sits between a host register bus and a byte-wide peripheral link in a parallel port controller. It owns the data latch, the control register and a sticky failure flag. It decides which host accesses become peripheral transfers. Accesses at offset 3 (address cycle) and offset 4 (data cycle) reach the peripheral only when the control register holds one exact bit pattern. One pattern allows writes and a different pattern allows reads. Offset 4 also accepts 16-bit and 32-bit accesses, which the block splits into bytes, lowest byte first.

Each byte moves over a request/acknowledge link. The peripheral can report an error with its acknowledge. A timer declares failure when no acknowledge arrives within `WAIT_LIMIT` cycles. A failure on an extended-mode transfer sets the sticky flag, which shows in bit 0 of the status readback. Software clears the flag by writing the status register with bit 0 set.

The block also drops writes that would not change the data latch or the control register. A change of the direction bit triggers a separate notice to the peripheral. A second register window (`host_ecp`) is inert.

The controller has four states:
- `ST_IDLE` accepts a request. It moves to `ST_RESP` for local accesses, to `ST_XFER` for a transfer, or to `ST_DIRN` for a control write that flips direction.
- `ST_DIRN` sends the direction notice. On acknowledge it moves to `ST_XFER`. On error or timeout it moves to `ST_RESP`.
- `ST_XFER` moves one byte per acknowledge. It moves to `ST_RESP` after the last byte, on an error, or on a timeout.
- `ST_RESP` raises `host_done` for one cycle and returns to `ST_IDLE`.

Top module: `epp_port_gate`

## Requirements
- R1: After reset the control readback (offset 2) is 0xCC and the data readback (offset 0) is 0xFF. The status readback is `ext_status` with bit 0 cleared. `per_req` is low.
- R2: An access at offset 3 or 4 is forwarded as a write (per_op 4 = address write, 5 = data write) only when control bits {5,3,2,1,0} equal exactly 0x04.
- R3: A read at offset 3 or 4 is forwarded (per_op 6 = address read, 7 = data read) only when control bits {5,3,2,1,0} equal exactly 0x24. A read that is not forwarded returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF for host_size 0, 1 or 2.
- R4: A write at offset 3 or 4 that fails its gate raises no peripheral request and completes locally.
- R5: host_size 1 and 2 at offset 4 move 2 and 4 bytes, lowest byte first, one byte per acknowledge. Read bytes fill host_rdata from bit 0 upward. Offset 3 always moves one byte.
- R6: An acknowledge with `per_err` high, or a timeout, on an extended-mode transfer sets the sticky flag and ends the access. The failing byte's data is kept. Read bytes that were never transferred stay 0xFF.
- R7: A status read (offset 1) returns `ext_status[7:1]` with the flag in bit 0. A status write with bit 0 set clears the flag. A status write with bit 0 clear leaves it.
- R8: A data write (offset 0) equal to the data latch is not forwarded. Otherwise it is sent as per_op 1, and the latch reads back the new value.
- R9: Control writes have bits 7:6 forced to 1 before storage and comparison. A write equal to the stored value is not forwarded. Any other is sent as per_op 2 carrying the forced value.
- R10: A control write that changes bit 5 first sends per_op 3 with the new bit 5 in per_wdata bit 0, then per_op 2.
- R11: Accesses with `host_ecp` high never reach the peripheral, and reads there return 0xFF. Reads at offsets 5 to 7 also return 0xFF.
- R12: A byte without acknowledge fails after exactly WAIT_LIMIT cycles. An acknowledge in the last waiting cycle still succeeds.
- R13: An access needing no peripheral transfer raises `host_done` in the cycle after acceptance. `host_done` is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Access request, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ecp | input | 1 | Selects the inert upper window |
| host_off | input | 3 | Register offset |
| host_size | input | 2 | 0 byte, 1 = 16-bit, 2 = 32-bit (offset 4 only) |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| ext_status | input | 8 | Status lines from the port |
| per_req | output | 1 | Byte request to the peripheral |
| per_op | output | 3 | Operation code (see R2, R3, R8 to R10) |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_ack | input | 1 | Byte accepted or returned |
| per_err | input | 1 | Failure, qualified by per_ack |
| per_rdata | input | 8 | Byte returned on reads |

## Verification
Assertions check three rules on every cycle:
- an extended-mode request never appears unless the control register holds its gate pattern;
- a waiting request keeps its operation and byte steady;
- the flag only rises after a failed extended-mode byte, and completion pulses last one cycle.

Other behaviour can only be seen through the bench's scenarios:
- byte order on wide accesses;
- the values returned by gated-off and partly failed reads;
- write suppression and the direction notice sequence;
- the exact timeout boundary.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DIRN, ST_XFER, ST_RESP} gate_state_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_DATA_WR = 3'd1,
        OP_CTRL_WR = 3'd2,
        OP_DIR_CHG = 3'd3,
        OP_EPP_AW  = 3'd4,
        OP_EPP_DW  = 3'd5,
        OP_EPP_AR  = 3'd6,
        OP_EPP_DR  = 3'd7
    } per_op_t;

    typedef enum logic [1:0] {DK_LOCAL, DK_XFER, DK_DIRX} dec_kind_t;

    typedef struct packed {
        dec_kind_t   kind;
        per_op_t     op;
        logic [1:0]  last_idx;
        logic [31:0] wbuf;
        logic [31:0] rinit;
        logic        is_epp;
        logic        set_data;
        logic        set_ctrl;
        logic [7:0]  new_val;
        logic        clr_flag;
    } dec_t;

    localparam logic [7:0] GATE_MASK  = 8'h2F;
    localparam logic [7:0] GATE_WR    = 8'h04;
    localparam logic [7:0] GATE_RD    = 8'h24;
    localparam logic [7:0] CTRL_FORCE = 8'hC0;
    localparam logic [7:0] CTRL_RST   = 8'hCC;
    localparam logic [7:0] DATA_RST   = 8'hFF;
endpackage

// File: rtl/epp_access_decode.sv
module epp_access_decode
    import epp_gate_pkg::*;
(
    input  logic        we,
    input  logic        ecp,
    input  logic [2:0]  off,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic [7:0]  ctrl,
    input  logic [7:0]  data,
    input  logic        flag,
    input  logic [7:0]  ext_status,
    output dec_t        dec
);
    logic [7:0]  wb;
    logic [7:0]  cv;
    logic        wgate;
    logic        rgate;
    logic [1:0]  lastw;
    logic [31:0] wmask;

    always_comb begin
        wb    = wdata[7:0];
        cv    = wb | CTRL_FORCE;
        wgate = (ctrl & GATE_MASK) == GATE_WR;
        rgate = (ctrl & GATE_MASK) == GATE_RD;
        lastw = (size == 2'd2) ? 2'd3 : (size == 2'd1) ? 2'd1 : 2'd0;
        wmask = (size == 2'd2) ? 32'hFFFF_FFFF : (size == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;

        dec       = '0;
        dec.kind  = DK_LOCAL;
        dec.op    = OP_NONE;
        dec.rinit = we ? 32'h0 : 32'h0000_00FF;

        if (!ecp) begin
            unique case (off)
                3'd0: begin
                    if (we) begin
                        if (wb != data) begin
                            dec.kind     = DK_XFER;
                            dec.op       = OP_DATA_WR;
                            dec.wbuf     = {24'h0, wb};
                            dec.set_data = 1'b1;
                            dec.new_val  = wb;
                        end
                    end else begin
                        dec.rinit = {24'h0, data};
                    end
                end
                3'd1: begin
                    if (we) dec.clr_flag = wb[0];
                    else    dec.rinit    = {24'h0, ext_status[7:1], flag};
                end
                3'd2: begin
                    if (we) begin
                        if (cv != ctrl) begin
                            dec.kind     = (cv[5] != ctrl[5]) ? DK_DIRX : DK_XFER;
                            dec.op       = OP_CTRL_WR;
                            dec.wbuf     = {24'h0, cv};
                            dec.set_ctrl = 1'b1;
                            dec.new_val  = cv;
                        end
                    end else begin
                        dec.rinit = {24'h0, ctrl};
                    end
                end
                3'd3: begin
                    if (we && wgate) begin
                        dec.kind   = DK_XFER;
                        dec.op     = OP_EPP_AW;
                        dec.wbuf   = {24'h0, wb};
                        dec.is_epp = 1'b1;
                    end else if (!we && rgate) begin
                        dec.kind   = DK_XFER;
                        dec.op     = OP_EPP_AR;
                        dec.is_epp = 1'b1;
                    end
                end
                3'd4: begin
                    if (!we) dec.rinit = wmask;
                    if (we && wgate) begin
                        dec.kind     = DK_XFER;
                        dec.op       = OP_EPP_DW;
                        dec.wbuf     = wdata;
                        dec.last_idx = lastw;
                        dec.is_epp   = 1'b1;
                    end else if (!we && rgate) begin
                        dec.kind     = DK_XFER;
                        dec.op       = OP_EPP_DR;
                        dec.last_idx = lastw;
                        dec.is_epp   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || ack)     cnt_q <= '0;
        else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && !ack && (cnt_q == LAST);

    // R12
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/epp_port_gate.sv
module epp_port_gate
    import epp_gate_pkg::*;
#(
    parameter int WAIT_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic        host_ecp,
    input  logic [2:0]  host_off,
    input  logic [1:0]  host_size,
    input  logic [31:0] host_wdata,
    output logic        host_busy,
    output logic        host_done,
    output logic [31:0] host_rdata,
    input  logic [7:0]  ext_status,
    output logic        per_req,
    output logic [2:0]  per_op,
    output logic [7:0]  per_wdata,
    input  logic        per_ack,
    input  logic        per_err,
    input  logic [7:0]  per_rdata
);
    gate_state_t state_q, state_d;
    dec_t        dec;
    per_op_t     op_q;
    logic [7:0]  ctrl_q, data_q;
    logic        flag_q, epp_q, expired;
    logic [1:0]  idx_q, last_q;
    logic [31:0] wbuf_q, rbuf_q;
    logic        is_read;

    epp_access_decode u_dec (
        .we(host_we), .ecp(host_ecp), .off(host_off), .size(host_size),
        .wdata(host_wdata), .ctrl(ctrl_q), .data(data_q), .flag(flag_q),
        .ext_status(ext_status), .dec(dec)
    );

    epp_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(per_req), .ack(per_ack), .expired(expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (host_req) begin
                unique case (dec.kind)
                    DK_XFER: state_d = ST_XFER;
                    DK_DIRX: state_d = ST_DIRN;
                    default: state_d = ST_RESP;
                endcase
            end
            ST_DIRN: if (per_ack) state_d = per_err ? ST_RESP : ST_XFER;
                     else if (expired) state_d = ST_RESP;
            ST_XFER: if (per_ack) begin
                         if (per_err || idx_q == last_q) state_d = ST_RESP;
                     end else if (expired) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign is_read = (op_q == OP_EPP_AR) || (op_q == OP_EPP_DR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            data_q <= DATA_RST;
            flag_q <= 1'b0;
            epp_q  <= 1'b0;
            op_q   <= OP_NONE;
            idx_q  <= '0;
            last_q <= '0;
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (state_q == ST_IDLE && host_req) begin
                op_q   <= dec.op;
                idx_q  <= '0;
                last_q <= dec.last_idx;
                wbuf_q <= dec.wbuf;
                rbuf_q <= dec.rinit;
                epp_q  <= dec.is_epp;
                if (dec.set_data) data_q <= dec.new_val;
                if (dec.set_ctrl) ctrl_q <= dec.new_val;
                if (dec.clr_flag) flag_q <= 1'b0;
            end
            if (state_q == ST_XFER) begin
                if (per_ack) begin
                    if (is_read) rbuf_q[{idx_q, 3'b000} +: 8] <= per_rdata;
                    if (per_err) flag_q <= flag_q | epp_q;
                    else if (idx_q != last_q) idx_q <= idx_q + 1'b1;
                end else if (expired) begin
                    flag_q <= flag_q | epp_q;
                end
            end
        end
    end

    always_comb begin
        per_req    = (state_q == ST_DIRN) || (state_q == ST_XFER);
        per_op     = (state_q == ST_DIRN) ? OP_DIR_CHG : op_q;
        per_wdata  = (state_q == ST_DIRN) ? {7'h0, ctrl_q[5]} : wbuf_q[{idx_q, 3'b000} +: 8];
        host_busy  = (state_q != ST_IDLE);
        host_done  = (state_q == ST_RESP);
        host_rdata = rbuf_q;
    end

    // R2
    epp_wgate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && (per_op == OP_EPP_AW || per_op == OP_EPP_DW) |-> (ctrl_q & GATE_MASK) == GATE_WR);
    // R3
    epp_rgate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && (per_op == OP_EPP_AR || per_op == OP_EPP_DR) |-> (ctrl_q & GATE_MASK) == GATE_RD);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && !per_ack && !expired |=> per_req && $stable(per_op) && $stable(per_wdata));
    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(epp_q && per_req && ((per_ack && per_err) || expired)));
    // R9
    ctrl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done && $past(host_req && !host_busy && !host_we && !host_ecp && host_off == 3'd2)
        |-> host_rdata[7:6] == 2'b11);
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
endmodule

// File: tb/epp_port_gate_tb.sv
module epp_port_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_ecp = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic [7:0]  ext_status = 8'hA5;
    logic        per_req;
    logic [2:0]  per_op;
    logic [7:0]  per_wdata;
    logic        per_ack = 1'b0, per_err = 1'b0;
    logic [7:0]  per_rdata = '0;

    int nchk = 0, nerr = 0;
    logic no_resp = 1'b0;
    int pdelay = 0, err_at = -1, wcnt = 0, nb = 0, lcnt = 0;
    logic [2:0] lop [0:255];
    logic [7:0] ldat [0:255];

    epp_port_gate #(.WAIT_LIMIT(WL)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_ecp(host_ecp), .host_off(host_off), .host_size(host_size),
        .host_wdata(host_wdata), .host_busy(host_busy), .host_done(host_done),
        .host_rdata(host_rdata), .ext_status(ext_status), .per_req(per_req),
        .per_op(per_op), .per_wdata(per_wdata), .per_ack(per_ack),
        .per_err(per_err), .per_rdata(per_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (per_req && !no_resp) begin
            if (wcnt >= pdelay) begin
                per_ack = 1'b1;
                per_err = (nb == err_at);
                per_rdata = 8'h30 + 8'(nb);
                lop[lcnt[7:0]] = per_op;
                ldat[lcnt[7:0]] = per_wdata;
                lcnt++;
                nb++;
                wcnt = 0;
            end else begin
                per_ack = 1'b0; per_err = 1'b0; wcnt++;
            end
        end else begin
            per_ack = 1'b0; per_err = 1'b0; wcnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic ecp, input logic [2:0] off,
                       input logic [1:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
        @(negedge clk);
        nb = 0;
        host_req = 1'b1; host_we = we; host_ecp = ecp;
        host_off = off; host_size = sz; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        cyc = 0;
        while (!host_done) begin
            @(posedge clk); @(negedge clk); cyc++;
        end
        rd = host_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cy, s;
        repeat (3) @(negedge clk);
        chk("R1 per_req", {31'h0, per_req}, 32'h0);
        rst_n = 1'b1;
        acc(0, 0, 2, 0, 0, rd, cy); chk("R1 ctrl", rd, 32'hCC);
        acc(0, 0, 0, 0, 0, rd, cy); chk("R1 data", rd, 32'hFF);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R1 status", rd, 32'hA4);
        chk("R13 local latency", cy, 0);

        // R2 R3 R4 R9: sweep all low control patterns
        for (int i = 0; i < 64; i++) begin
            logic [7:0] cv;
            cv = 8'(i) | 8'hC0;
            acc(1, 0, 2, 0, 32'(i), rd, cy);
            acc(0, 0, 2, 0, 0, rd, cy); chk("R9 ctrl readback", rd, {24'h0, cv});
            s = lcnt; acc(1, 0, 3, 0, 32'h77, rd, cy);
            chk("R2 R4 addr write gate", lcnt - s, ((cv & 8'h2F) == 8'h04) ? 1 : 0);
            s = lcnt; acc(0, 0, 3, 0, 0, rd, cy);
            chk("R3 addr read gate", lcnt - s, ((cv & 8'h2F) == 8'h24) ? 1 : 0);
            chk("R3 addr read value", rd, ((cv & 8'h2F) == 8'h24) ? 32'h30 : 32'hFF);
        end

        // R5 wide writes
        acc(1, 0, 2, 0, 32'h04, rd, cy);
        s = lcnt; acc(1, 0, 4, 2, 32'h44332211, rd, cy);
        chk("R5 cycles32", cy, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R5 op", {29'h0, lop[s+k]}, 32'd5);
            chk("R5 byte order", {24'h0, ldat[s+k]}, 32'h11 * (k + 1));
        end
        s = lcnt; acc(1, 0, 4, 1, 32'h0000BEEF, rd, cy);
        chk("R5 count16", lcnt - s, 2);
        chk("R5 lo16", {24'h0, ldat[s]}, 32'hEF);
        chk("R5 hi16", {24'h0, ldat[s+1]}, 32'hBE);

        // R5 wide reads
        acc(1, 0, 2, 0, 32'h24, rd, cy);
        acc(0, 0, 4, 2, 0, rd, cy); chk("R5 read32", rd, 32'h33323130);
        acc(0, 0, 4, 1, 0, rd, cy); chk("R5 read16", rd, 32'h3130);
        acc(0, 0, 4, 0, 0, rd, cy); chk("R5 read8", rd, 32'h30);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R7 flag clear", rd, 32'hA4);

        // R6 error mid-transfer
        err_at = 1;
        s = lcnt; acc(0, 0, 4, 2, 0, rd, cy);
        err_at = -1;
        chk("R6 partial read", rd, 32'hFFFF3130);
        chk("R6 abort count", lcnt - s, 2);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R6 R7 flag set", rd, 32'hA5);
        acc(1, 0, 1, 0, 32'hFE, rd, cy);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R7 bit0 clear keeps", rd, 32'hA5);
        acc(1, 0, 1, 0, 32'h01, rd, cy);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R7 clear", rd, 32'hA4);

        // R12 timeout boundary
        no_resp = 1'b1;
        acc(0, 0, 3, 0, 0, rd, cy);
        no_resp = 1'b0;
        chk("R12 timeout cycles", cy, WL);
        chk("R12 timeout data", rd, 32'hFF);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R6 timeout flag", rd, 32'hA5);
        acc(1, 0, 1, 0, 32'h01, rd, cy);
        pdelay = WL - 1;
        acc(0, 0, 3, 0, 0, rd, cy);
        pdelay = 0;
        chk("R12 late ack cycles", cy, WL);
        chk("R12 late ack data", rd, 32'h30);
        acc(0, 0, 1, 0, 0, rd, cy); chk("R12 late ack no flag", rd, 32'hA4);

        // R8 redundant data write
        s = lcnt; acc(1, 0, 0, 0, 32'h5A, rd, cy);
        chk("R8 forward", lcnt - s, 1);
        chk("R8 op", {29'h0, lop[s]}, 32'd1);
        chk("R8 byte", {24'h0, ldat[s]}, 32'h5A);
        s = lcnt; acc(1, 0, 0, 0, 32'h5A, rd, cy);
        chk("R8 suppressed", lcnt - s, 0);
        acc(0, 0, 0, 0, 0, rd, cy); chk("R8 latch", rd, 32'h5A);

        // R9 R10 control writes
        s = lcnt; acc(1, 0, 2, 0, 32'h24, rd, cy);
        chk("R9 redundant ctrl", lcnt - s, 0);
        s = lcnt; acc(1, 0, 2, 0, 32'h04, rd, cy);
        chk("R10 count", lcnt - s, 2);
        chk("R10 dir op", {29'h0, lop[s]}, 32'd3);
        chk("R10 dir bit", {24'h0, ldat[s]}, 32'h00);
        chk("R10 ctrl op", {29'h0, lop[s+1]}, 32'd2);
        chk("R10 ctrl val", {24'h0, ldat[s+1]}, 32'hC4);
        chk("R10 cycles", cy, 2);
        s = lcnt; acc(1, 0, 2, 0, 32'h06, rd, cy);
        chk("R9 single ctrl", lcnt - s, 1);
        chk("R9 ctrl val", {24'h0, ldat[s]}, 32'hC6);

        // R11 inert window
        s = lcnt; acc(1, 1, 0, 0, 32'h12, rd, cy);
        chk("R11 ecp write", lcnt - s, 0);
        acc(0, 1, 0, 0, 0, rd, cy); chk("R11 ecp read", rd, 32'hFF);
        acc(0, 0, 5, 0, 0, rd, cy); chk("R11 off5 read", rd, 32'hFF);

        // R3 R4 gated-off widths (ctrl now 0xC6)
        acc(0, 0, 4, 1, 0, rd, cy); chk("R3 gated16", rd, 32'hFFFF);
        acc(0, 0, 4, 2, 0, rd, cy); chk("R3 gated32", rd, 32'hFFFFFFFF);
        s = lcnt; acc(1, 0, 4, 2, 32'h1234, rd, cy);
        chk("R4 gated data write", lcnt - s, 0);
        chk("R13 gated latency", cy, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule